// File: doc/BRIEF.md
# Egress Transmit Timestamp Queue

This block keeps transmit timestamps for frames that a port sends out and that have been marked for two-step timing. On each capture strobe from the egress path it takes the running time of day and stores one entry holding the nanosecond count and the lowest bit of the seconds count. The entry also holds the tag that the frame carried: a timestamp ID, the egress port number and the message sequence number. Entries from all ports go into one shared first-in first-out store.

Software drains the store through a small register port. A status word shows whether there is a head entry, whether an overflow has happened, and the head's ID, port and sequence number. A stamp word gives the head's time. A write to the control word with the next bit set pops the head and exposes the following entry. The stored seconds bit lets software compare against the live seconds count and detect a rollover between capture and readout. Timestamp IDs are allocated per port and wrap at a fixed maximum, and the number of frames in flight is bounded by the store depth. Both are managed upstream, and the block only carries the tag it is given.

Top module: `egress_tstamp_fifo`

## Requirements
- R1: After reset the store is empty and the status word reads valid (bit 0) and overflow (bit 1) both 0.
- R2: A capture strobe stores the time-of-day nanoseconds and seconds bit 0 present in that cycle, together with the ID, port and sequence inputs. The entry is readable from the third clock edge after the strobe onward. The status word has valid in bit 0, overflow in bit 1, ID in bits 3:2, port in bits 7:4 and sequence in bits 23:8. The stamp word has nanoseconds in bits 29:0 and the seconds bit in bit 30.
- R3: Entries leave in the order they were captured. A control write (address 2) with bit 0 set removes the head.
- R4: When the store is empty, a status read returns valid 0 with ID, port and sequence 0, and a stamp read returns 0.
- R5: A capture arriving while the store is full, with no pop in the same cycle, is dropped and sets the overflow flag. The flag stays set, and the stored entries are unchanged.
- R6: A control write with bit 1 set clears the overflow flag.
- R7: A capture reaching a full store in the same cycle as a pop is accepted: the head leaves, the new entry joins at the tail and overflow stays clear.
- R8: A pop while the store is empty has no effect.
- R9: The store holds exactly DEPTH entries before a further capture overflows.
- R10: Reads use address 0 for status and 1 for stamp. The read data is registered and appears after the clock edge that takes the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tod_ns | input | 30 | Running nanoseconds of the time of day |
| tod_sec0 | input | 1 | Bit 0 of the running seconds count |
| cap_vld | input | 1 | Capture strobe from the egress path |
| cap_id | input | 2 | Timestamp ID of the departing frame |
| cap_port | input | 4 | Egress port number |
| cap_seq | input | 16 | Message sequence number |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 status, 1 stamp, 2 control |
| reg_wdata | input | 2 | Control write data: bit 0 next, bit 1 clear overflow |
| reg_rdata | output | 32 | Registered read data |

## Verification
A pointer or count that has gone wrong shows at the ports on the next status or stamp read. The head's ID, port or sequence then belongs to the wrong capture, or valid reads 1 over an empty store. An overflow decision in the wrong cycle shows as one entry too many or too few when the store is drained after a fill of exactly DEPTH. The same-cycle pop-and-capture case is the one where a wrong count hides longest. It first shows after the following full drain, so the bench drains completely after that case.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  typedef enum logic [1:0] {
    ADDR_STATUS = 2'd0,
    ADDR_STAMP  = 2'd1,
    ADDR_CTRL   = 2'd2
  } tsf_addr_e;

  localparam int CTRL_NEXT_BIT = 0;
  localparam int CTRL_CLR_BIT  = 1;
endpackage

// File: rtl/tsf_capture.sv
module tsf_capture #(
  parameter int ENT_W = 53
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_vld,
  input  logic [ENT_W-1:0] cap_word,
  output logic             ent_vld,
  output logic [ENT_W-1:0] ent_word
);
  // One register stage: time and tag are frozen in the strobe cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      ent_vld  <= 1'b0;
      ent_word <= '0;
    end else begin
      ent_vld <= cap_vld;
      if (cap_vld) ent_word <= cap_word;
    end
  end
endmodule

// File: rtl/tsf_fifo.sv
module tsf_fifo #(
  parameter int W     = 53,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  input  logic         clr_ovf,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full,
  output logic         ovf
);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [AW-1:0]    LAST = AW'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_pop, do_wr, drop;

  assign empty  = (count == '0);
  assign full   = (count == FULL_CNT);
  assign do_pop = pop && !empty;
  assign do_wr  = wr && (!full || do_pop);
  assign drop   = wr && full && !do_pop;
  assign head   = mem[rd_ptr];

  // Storage without reset so it maps onto RAM.
  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (do_wr)  wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_wr, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (drop)         ovf <= 1'b1;
      else if (clr_ovf) ovf <= 1'b0;
    end
  end

  assert_count_bound_R9: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);
  assert_ovf_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> $past(wr && full && !pop));
  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (ovf && !clr_ovf) |=> ovf);
  assert_same_cycle_R7: assert property (@(posedge clk) disable iff (rst)
    (wr && pop && !empty) |=> (count == $past(count)));
  assert_empty_pop_R8: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !wr) |=> empty);
endmodule

// File: rtl/tsf_regif.sv
module tsf_regif
  import tsf_pkg::*;
#(
  parameter int NS_W   = 30,
  parameter int ID_W   = 2,
  parameter int PORT_W = 4,
  parameter int SEQ_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 reg_rd,
  input  logic                                 reg_wr,
  input  logic [1:0]                           reg_addr,
  input  logic [1:0]                           reg_wdata,
  input  logic [SEQ_W+PORT_W+ID_W+NS_W:0]      head,
  input  logic                                 empty,
  input  logic                                 ovf,
  output logic                                 pop,
  output logic                                 clr_ovf,
  output logic [DATA_W-1:0]                    rdata
);
  localparam int ID_LO   = NS_W + 1;
  localparam int PORT_LO = ID_LO + ID_W;
  localparam int SEQ_LO  = PORT_LO + PORT_W;
  localparam int TAG_W   = ID_W + PORT_W + SEQ_W;
  localparam int STAT_W  = TAG_W + 2;
  localparam int STMP_W  = NS_W + 1;

  logic [TAG_W-1:0]  tag;
  logic [STAT_W-1:0] status_v;
  logic [STMP_W-1:0] stamp_v;
  logic              is_ctrl_wr;

  assign tag      = empty ? '0 : {head[SEQ_LO +: SEQ_W], head[PORT_LO +: PORT_W],
                                  head[ID_LO +: ID_W]};
  assign status_v = {tag, ovf, !empty};
  assign stamp_v  = empty ? '0 : head[NS_W:0];

  assign is_ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
  assign pop        = is_ctrl_wr && reg_wdata[CTRL_NEXT_BIT];
  assign clr_ovf    = is_ctrl_wr && reg_wdata[CTRL_CLR_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        ADDR_STATUS: rdata <= DATA_W'(status_v);
        ADDR_STAMP:  rdata <= DATA_W'(stamp_v);
        default:     rdata <= '0;
      endcase
    end
  end

  assert_empty_status_R4: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == ADDR_STATUS && empty) |=>
      (rdata[0] == 1'b0 && rdata[DATA_W-1:2] == '0));
  assert_empty_stamp_R4: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == ADDR_STAMP && empty) |=> (rdata == '0));
endmodule

// File: rtl/egress_tstamp_fifo.sv
module egress_tstamp_fifo #(
  parameter int NS_W   = 30,
  parameter int ID_W   = 2,
  parameter int PORT_W = 4,
  parameter int SEQ_W  = 16,
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NS_W-1:0]   tod_ns,
  input  logic              tod_sec0,
  input  logic              cap_vld,
  input  logic [ID_W-1:0]   cap_id,
  input  logic [PORT_W-1:0] cap_port,
  input  logic [SEQ_W-1:0]  cap_seq,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [1:0]        reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam int ENT_W = SEQ_W + PORT_W + ID_W + NS_W + 1;

  logic [ENT_W-1:0] cap_word, ent_word, head;
  logic             ent_vld, empty, full, ovf, pop, clr_ovf;

  assign cap_word = {cap_seq, cap_port, cap_id, tod_sec0, tod_ns};

  tsf_capture #(.ENT_W(ENT_W)) u_cap (
    .clk(clk), .rst(rst), .cap_vld(cap_vld), .cap_word(cap_word),
    .ent_vld(ent_vld), .ent_word(ent_word)
  );

  tsf_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr(ent_vld), .wdata(ent_word), .pop(pop),
    .clr_ovf(clr_ovf), .head(head), .empty(empty), .full(full), .ovf(ovf)
  );

  tsf_regif #(.NS_W(NS_W), .ID_W(ID_W), .PORT_W(PORT_W), .SEQ_W(SEQ_W),
              .DATA_W(DATA_W)) u_reg (
    .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .head(head), .empty(empty),
    .ovf(ovf), .pop(pop), .clr_ovf(clr_ovf), .rdata(reg_rdata)
  );
endmodule

// File: tb/sim_egress_tstamp_fifo.sv
module sim_egress_tstamp_fifo;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [29:0] tod_ns = '0;
  logic        tod_sec0 = 1'b0;
  logic        cap_vld = 1'b0;
  logic [1:0]  cap_id = '0;
  logic [3:0]  cap_port = '0;
  logic [15:0] cap_seq = '0;
  logic        reg_rd = 1'b0, reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0, reg_wdata = '0;
  logic [31:0] reg_rdata;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [52:0] sb [$];   // {seq, port, id, sec0, ns}

  always #4 clk = ~clk;

  egress_tstamp_fifo u0 (
    .clk(clk), .rst(rst), .tod_ns(tod_ns), .tod_sec0(tod_sec0),
    .cap_vld(cap_vld), .cap_id(cap_id), .cap_port(cap_port), .cap_seq(cap_seq),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic ctrl(input logic [1:0] w);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = w;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  // Driver: one capture, expected entry pushed to the scoreboard unless dropped.
  task automatic cap(input logic [29:0] ns, input logic s0, input logic [1:0] id,
                     input logic [3:0] p, input logic [15:0] sq, input bit keep);
    @(negedge clk);
    cap_vld = 1'b1; tod_ns = ns; tod_sec0 = s0; cap_id = id; cap_port = p; cap_seq = sq;
    @(negedge clk); cap_vld = 1'b0; tod_ns = ns + 30'd8;
    @(negedge clk);
    if (keep) sb.push_back({sq, p, id, s0, ns});
  endtask

  // Monitor: read head, compare with scoreboard front, then pop.
  task automatic check_head(input string req, input logic ovf_exp);
    logic [31:0] st, tm;
    logic [52:0] e;
    e = sb.pop_front();
    rd(2'd0, st);
    rd(2'd1, tm);
    check({req, " status"}, st, {8'd0, e[52:31], ovf_exp, 1'b1});
    check({req, " stamp"}, tm, {1'b0, e[30:0]});
    ctrl(2'b01);
  endtask

  task automatic check_empty(input string req, input logic ovf_exp);
    logic [31:0] st, tm;
    rd(2'd0, st);
    rd(2'd1, tm);
    check({req, " empty status"}, st, {30'd0, ovf_exp, 1'b0});
    check({req, " empty stamp"}, tm, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 / R4: reset state, empty reads
    check_empty("R1", 1'b0);

    // R2 / R3 / R10: capture distinct patterns, read back in order
    cap(30'h3FFF_FFFF, 1'b1, 2'd3, 4'd15, 16'hFFFF, 1);
    cap(30'd0,         1'b0, 2'd0, 4'd0,  16'h0000, 1);
    cap(30'h1234_5678, 1'b1, 2'd1, 4'd9,  16'hA55A, 1);
    check_head("R2", 1'b0);
    check_head("R3", 1'b0);
    check_head("R10", 1'b0);
    check_empty("R4", 1'b0);

    // R8: pop on empty has no effect
    ctrl(2'b01);
    check_empty("R8", 1'b0);
    cap(30'd777, 1'b0, 2'd2, 4'd5, 16'd42, 1);
    check_head("R8", 1'b0);

    // R9 / R5: fill exactly DEPTH, one more is dropped
    for (int i = 0; i < DEPTH; i++)
      cap(30'(100 * i + 5), 1'(i), 2'(i), 4'(i + 1), 16'(1000 + i), 1);
    begin
      logic [31:0] st;
      rd(2'd0, st);
      check("R9 full no ovf", {30'd0, st[1], st[0]}, 32'd1);
    end
    cap(30'd999, 1'b1, 2'd3, 4'd3, 16'hDEAD, 0);
    for (int i = 0; i < DEPTH; i++) check_head("R5", 1'b1);
    check_empty("R5 sticky", 1'b1);

    // R6: clear overflow
    ctrl(2'b10);
    check_empty("R6", 1'b0);

    // R7: capture into a full store in the same cycle as a pop
    for (int i = 0; i < DEPTH; i++)
      cap(30'(50 + i), 1'(i + 1), 2'(i + 2), 4'(i), 16'(2000 + i), 1);
    @(negedge clk);
    cap_vld = 1'b1; tod_ns = 30'h2AAA_AAAA; tod_sec0 = 1'b1;
    cap_id = 2'd1; cap_port = 4'd12; cap_seq = 16'hBEEF;
    @(negedge clk);
    cap_vld = 1'b0; reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 2'b01;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
    void'(sb.pop_front());
    sb.push_back({16'hBEEF, 4'd12, 2'd1, 1'b1, 30'h2AAA_AAAA});
    for (int i = 0; i < DEPTH; i++) check_head("R7", 1'b0);
    check_empty("R7", 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule